// File: doc/BRIEF.md
# PS/2 Keyboard Host Controller

This block is the host end of a two-wire PS/2 keyboard link. Both link wires are open-drain. Each wire has a sampled input and an output-enable, and the enable pulls the wire low when it is set. Frames from the keyboard are synchronised, framed, parity-checked and translated from raw scan codes into system codes. The result is held in a one-byte output buffer. While that buffer is full, the interrupt request output is high. A break prefix makes the next code come out with its top bit set. Frames with a bad parity bit or a bad stop bit are dropped and flagged.

The CPU side has a two-register port selected by `cpu_sel`. Select 0 is the data register and select 1 is the status register. Writing the data register hands a command byte to the transmitter. The transmitter inhibits the link, issues a request to send and shifts the byte out on the keyboard's clock with odd parity added. It then stays busy until the keyboard answers with its acknowledge code. Writes made while it is busy are dropped.

The receive machine has four states: RX_IDLE, RX_DATA, RX_PARITY and RX_STOP.
- RX_IDLE moves to RX_DATA on a falling clock edge with data low.
- RX_DATA moves to RX_PARITY after the eighth data edge.
- RX_PARITY moves to RX_STOP on the next edge.
- RX_STOP returns to RX_IDLE on the stop edge, which reports either a good byte or an error.
- The machine is held in RX_IDLE while the transmitter owns the wires.

The transmit machine has four states: TX_IDLE, TX_INHIBIT, TX_SHIFT and TX_WAIT_ACK.
- TX_IDLE moves to TX_INHIBIT when the data register is written.
- TX_INHIBIT moves to TX_SHIFT once the inhibit count expires.
- TX_SHIFT moves to TX_WAIT_ACK on the eleventh falling keyboard clock edge.
- TX_WAIT_ACK returns to TX_IDLE when an acknowledge byte is received.

Top module: `kbd_host_ctrl`

## Requirements
- R1: After reset, `irq_kbd`, `ps2_clk_oe` and `ps2_dat_oe` are 0, and the status register reads 0x00.
- R2: A receive frame has these fields, each taken on a falling clock edge: a start bit of 0, eight data bits with the LSB first, a parity bit and a stop bit of 1. The frame is accepted only if the nine data and parity bits hold an odd number of ones and the stop bit is 1. Otherwise it is discarded and status bit 2 (parity error) is set. Bit 2 clears when the status register is read.
- R3: Accepted bytes are translated before buffering as follows:
  - 0x1C becomes 0x1E
  - 0x32 becomes 0x30
  - 0x21 becomes 0x2E
  - 0x23 becomes 0x20
  - 0x24 becomes 0x12
  - 0x29 becomes 0x39
  - 0x5A becomes 0x1C
  - 0x76 becomes 0x01
  - every other byte passes through unchanged.
- R4: A received 0xF0 is not buffered. The next buffered code is then its translation with bit 7 set, and the break marker clears after that code.
- R5: `irq_kbd` is high exactly while the output buffer is full. Reading the data register (`cpu_sel`=0 with `cpu_rd`) clears it. A new byte that arrives while the buffer is full replaces the old one.
- R6: The status register has bit 0 = output buffer full, bit 1 = transmit pending and bit 2 = parity error. The upper bits read 0.
- R7: Writing the data register while idle pulls the clock low for exactly INHIBIT_CYCLES cycles. When the clock is released, the data line is already pulled low as the start bit.
- R8: On the first ten falling keyboard clock edges after the clock is released, the host drives the next bit of the frame:
  - edges 1 to 8 carry data bits 0 to 7, LSB first
  - edge 9 carries the odd parity bit
  - edge 10 carries a released (1) stop bit.
  The eleventh edge ends the shift.
- R9: Transmit pending stays set until 0xFA is received. That 0xFA is consumed without being buffered. Data register writes made while transmit pending is set are ignored.
- R10: A 0xFA received with no transmit pending is buffered like any other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Sampled level of the PS/2 clock wire |
| ps2_dat_i | input | 1 | Sampled level of the PS/2 data wire |
| ps2_clk_oe | output | 1 | 1 pulls the PS/2 clock wire low |
| ps2_dat_oe | output | 1 | 1 pulls the PS/2 data wire low |
| cpu_sel | input | 1 | Register select: 0 data, 1 status |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle; a data read empties the buffer |
| cpu_wdata | input | 8 | Write data (command byte) |
| cpu_rdata | output | 8 | Read data for the selected register |
| irq_kbd | output | 1 | Keyboard interrupt request, high while the buffer is full |

## Verification
The assertions assume that the keyboard drives its clock only when the host is not inhibiting the link. They also assume that each clock phase lasts much longer than the two-stage synchroniser plus edge detector, so every falling edge is seen exactly once. Read and write strobes are taken to last one cycle, with `cpu_sel` stable while they are high. The bench keeps to these conditions with a keyboard model whose half-period is 20 system cycles. That model drives its data only while its clock is high, or during the low phase of the acknowledge bit. The model also stays silent while `ps2_clk_oe` is set, and all CPU strobes are issued at falling system-clock edges.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_INHIBIT,
        TX_SHIFT,
        TX_WAIT_ACK
    } tx_state_t;

    localparam logic [BYTE_W-1:0] ACK_CODE     = 8'hFA;
    localparam logic [BYTE_W-1:0] BREAK_PREFIX = 8'hF0;

    localparam int ST_OBF  = 0;
    localparam int ST_IBF  = 1;
    localparam int ST_PERR = 2;
endpackage

// File: rtl/kbd_rx.sv
module kbd_rx
    import kbd_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fall,
    input  logic              din,
    output logic              valid,
    output logic              err,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    rx_state_t         st, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              par;

    always_comb begin
        nxt = st;
        unique case (st)
            RX_IDLE:   if (fall && !din) nxt = RX_DATA;
            RX_DATA:   if (fall && cnt == CNT_LAST) nxt = RX_PARITY;
            RX_PARITY: if (fall) nxt = RX_STOP;
            RX_STOP:   if (fall) nxt = RX_IDLE;
        endcase
        if (!en) nxt = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            par   <= 1'b0;
            valid <= 1'b0;
            err   <= 1'b0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (fall) begin
                unique case (st)
                    RX_IDLE:   cnt <= '0;
                    RX_DATA: begin
                        shreg <= {din, shreg[DATA_W-1:1]};
                        cnt   <= cnt + 1'b1;
                    end
                    RX_PARITY: par <= din;
                    RX_STOP: begin
                        if (din && ((^shreg) ^ par)) valid <= 1'b1;
                        else                         err   <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign rx_byte = shreg;

    // R2: a frame yields either a byte or an error, never both
    a_r2_valid_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && err));

    // R2: results appear only after a sampled clock edge
    a_r2_result_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (valid || err) |-> $past(fall));
endmodule

// File: rtl/kbd_tx.sv
module kbd_tx
    import kbd_pkg::*;
#(
    parameter int DATA_W         = BYTE_W,
    parameter int INHIBIT_CYCLES = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  logic              ack,
    output logic              clk_oe,
    output logic              dat_oe,
    output logic              pending,
    output logic              waiting,
    output logic              line_busy
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int INH_W   = (INHIBIT_CYCLES > 1) ? $clog2(INHIBIT_CYCLES) : 1;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam logic [INH_W-1:0] INH_LAST = INH_W'(INHIBIT_CYCLES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W + 2);

    tx_state_t          st, nxt;
    logic [INH_W-1:0]   inh_cnt;
    logic [BIT_W-1:0]   bcnt;
    logic [FRAME_W-1:0] sh;

    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE:     if (start) nxt = TX_INHIBIT;
            TX_INHIBIT:  if (inh_cnt == INH_LAST) nxt = TX_SHIFT;
            TX_SHIFT:    if (fall && bcnt == BIT_LAST) nxt = TX_WAIT_ACK;
            TX_WAIT_ACK: if (ack) nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inh_cnt <= '0;
            bcnt    <= '0;
            sh      <= '1;
        end else begin
            unique case (st)
                TX_IDLE: if (start) begin
                    sh      <= {1'b1, ~(^din), din, 1'b0};
                    inh_cnt <= '0;
                    bcnt    <= '0;
                end
                TX_INHIBIT: inh_cnt <= inh_cnt + 1'b1;
                TX_SHIFT: if (fall) begin
                    sh   <= {1'b1, sh[FRAME_W-1:1]};
                    bcnt <= bcnt + 1'b1;
                end
                TX_WAIT_ACK: ;
            endcase
        end
    end

    always_comb begin
        clk_oe    = (st == TX_INHIBIT);
        dat_oe    = (st == TX_SHIFT) && !sh[0];
        pending   = (st != TX_IDLE);
        waiting   = (st == TX_WAIT_ACK);
        line_busy = (st == TX_INHIBIT) || (st == TX_SHIFT);
    end

    // R7: the clock is released only with the start bit already on the data wire
    a_r7_start_bit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_oe) |-> dat_oe);

    // R7: the inhibit phase never ends before its count expires
    a_r7_inhibit_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_INHIBIT && inh_cnt != INH_LAST) |=> st == TX_INHIBIT);

    // R9: the transmitter stays busy until the acknowledge arrives
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_WAIT_ACK && !ack) |=> st == TX_WAIT_ACK);

    // R9: a write while busy leaves the pending frame untouched
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == TX_INHIBIT || st == TX_WAIT_ACK) && start) |=> $stable(sh));
endmodule

// File: rtl/kbd_xlate.sv
module kbd_xlate
    import kbd_pkg::*;
(
    input  logic [BYTE_W-1:0] raw,
    input  logic              brk,
    output logic [BYTE_W-1:0] code
);
    logic [BYTE_W-1:0] base;

    always_comb begin
        case (raw)
            8'h1C:   base = 8'h1E;
            8'h32:   base = 8'h30;
            8'h21:   base = 8'h2E;
            8'h23:   base = 8'h20;
            8'h24:   base = 8'h12;
            8'h29:   base = 8'h39;
            8'h5A:   base = 8'h1C;
            8'h76:   base = 8'h01;
            default: base = raw;
        endcase
        code = base | {brk, {(BYTE_W-1){1'b0}}};
    end
endmodule

// File: rtl/kbd_host_ctrl.sv
module kbd_host_ctrl
    import kbd_pkg::*;
#(
    parameter int INHIBIT_CYCLES = 20000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ps2_clk_i,
    input  logic              ps2_dat_i,
    output logic              ps2_clk_oe,
    output logic              ps2_dat_oe,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              irq_kbd
);
    logic [SYNC_STAGES-1:0] clk_sync, dat_sync;
    logic                   clk_prev;
    logic                   fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sync <= '1;
            dat_sync <= '1;
            clk_prev <= 1'b1;
        end else begin
            clk_sync <= {clk_sync[SYNC_STAGES-2:0], ps2_clk_i};
            dat_sync <= {dat_sync[SYNC_STAGES-2:0], ps2_dat_i};
            clk_prev <= clk_sync[SYNC_STAGES-1];
        end
    end

    assign fall = clk_prev && !clk_sync[SYNC_STAGES-1];

    logic              rx_valid, rx_err;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_pending, tx_waiting, tx_line_busy;
    logic              is_ack, is_prefix, buf_load, tx_start;
    logic [BYTE_W-1:0] xcode;
    logic [BYTE_W-1:0] obuf;
    logic              obf, perr, brk;

    kbd_rx #(.DATA_W(BYTE_W)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!tx_line_busy),
        .fall    (fall),
        .din     (dat_sync[SYNC_STAGES-1]),
        .valid   (rx_valid),
        .err     (rx_err),
        .rx_byte (rx_byte)
    );

    assign tx_start = cpu_wr && !cpu_sel;

    kbd_tx #(.DATA_W(BYTE_W), .INHIBIT_CYCLES(INHIBIT_CYCLES)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .start     (tx_start),
        .din       (cpu_wdata),
        .ack       (is_ack),
        .clk_oe    (ps2_clk_oe),
        .dat_oe    (ps2_dat_oe),
        .pending   (tx_pending),
        .waiting   (tx_waiting),
        .line_busy (tx_line_busy)
    );

    kbd_xlate xlate_i (
        .raw  (rx_byte),
        .brk  (brk),
        .code (xcode)
    );

    assign is_ack    = rx_valid && tx_waiting && (rx_byte == ACK_CODE);
    assign is_prefix = rx_valid && !is_ack && (rx_byte == BREAK_PREFIX);
    assign buf_load  = rx_valid && !is_ack && !is_prefix;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obuf <= '0;
            obf  <= 1'b0;
            perr <= 1'b0;
            brk  <= 1'b0;
        end else begin
            if (buf_load) begin
                obuf <= xcode;
                obf  <= 1'b1;
                brk  <= 1'b0;
            end else begin
                if (cpu_rd && !cpu_sel) obf <= 1'b0;
                if (is_prefix)          brk <= 1'b1;
            end
            if (rx_err)                perr <= 1'b1;
            else if (cpu_rd && cpu_sel) perr <= 1'b0;
        end
    end

    logic [BYTE_W-1:0] status;
    always_comb begin
        status          = '0;
        status[ST_OBF]  = obf;
        status[ST_IBF]  = tx_pending;
        status[ST_PERR] = perr;
        cpu_rdata       = cpu_sel ? status : obuf;
        irq_kbd         = obf;
    end

    // R5: a data read with no byte arriving drops the interrupt
    a_r5_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_sel && !buf_load) |=> !irq_kbd);

    // R2: a rejected frame raises the error flag
    a_r2_error_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> cpu_rdata[ST_PERR] || !cpu_sel);

    // R9: the acknowledge byte never reaches the output buffer
    a_r9_ack_not_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        is_ack |=> $stable(obuf));

    // R4: a break prefix is never buffered
    a_r4_prefix_not_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        is_prefix |=> $stable(obuf));
endmodule

// File: tb/kbd_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module kbd_host_ctrl_tb_top;
    localparam int INH  = 200;
    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kb_clk = 1'b1, kb_dat = 1'b1;
    logic       ps2_clk_oe, ps2_dat_oe;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       irq_kbd;
    logic       line_clk, line_dat;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign line_clk = kb_clk & ~ps2_clk_oe;
    assign line_dat = kb_dat & ~ps2_dat_oe;

    kbd_host_ctrl #(.INHIBIT_CYCLES(INH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps2_clk_i  (line_clk),
        .ps2_dat_i  (line_dat),
        .ps2_clk_oe (ps2_clk_oe),
        .ps2_dat_oe (ps2_dat_oe),
        .cpu_sel    (cpu_sel),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .irq_kbd    (irq_kbd)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] model_xlate(input logic [7:0] b);
        case (b)
            8'h1C: return 8'h1E;
            8'h32: return 8'h30;
            8'h21: return 8'h2E;
            8'h23: return 8'h20;
            8'h24: return 8'h12;
            8'h29: return 8'h39;
            8'h5A: return 8'h1C;
            8'h76: return 8'h01;
            default: return b;
        endcase
    endfunction

    task automatic cpu_write(input logic s, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic s, output logic [7:0] v);
        @(negedge clk);
        cpu_sel = s; cpu_rd = 1'b1;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic peek_status(output logic [7:0] v);
        @(negedge clk);
        cpu_sel = 1'b1;
        #1 v = cpu_rdata;
    endtask

    task automatic kb_send(input logic [7:0] b, input logic bad_par, input logic bad_stop);
        logic [10:0] fr;
        fr = {~bad_stop, (~(^b)) ^ bad_par, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            kb_dat = fr[i];
            wait_cyc(HALF);
            kb_clk = 1'b0;
            wait_cyc(HALF);
            kb_clk = 1'b1;
        end
        kb_dat = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic expect_code(input string req, input logic [7:0] exp);
        logic [7:0] v;
        chk({req, " irq"}, int'(irq_kbd), 1);
        cpu_read(1'b0, v);
        chk({req, " code"}, int'(v), int'(exp));
        wait_cyc(1);
        chk({req, " irq clear"}, int'(irq_kbd), 0);
    endtask

    task automatic host_cycle(input logic [7:0] exp);
        int cnt;
        logic [9:0] got;
        cnt = 0;
        for (int g = 0; g < 5 && !ps2_clk_oe; g++) @(negedge clk);
        while (ps2_clk_oe && cnt < INH + 10) begin
            cnt++;
            @(negedge clk);
        end
        chk("R7 inhibit length", cnt, INH);
        chk("R7 start bit low at release", int'(ps2_dat_oe), 1);
        wait_cyc(HALF);
        for (int k = 0; k < 10; k++) begin
            kb_clk = 1'b0;
            wait_cyc(HALF);
            got[k] = line_dat;
            kb_clk = 1'b1;
            wait_cyc(HALF);
        end
        chk("R8 data bits", int'(got[7:0]), int'(exp));
        chk("R8 odd parity", int'(^got[8:0]), 1);
        chk("R8 stop released", int'(got[9]), 1);
        kb_dat = 1'b0;
        kb_clk = 1'b0;
        wait_cyc(HALF);
        kb_clk = 1'b1;
        kb_dat = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek_status(v);
        chk("R1 status", int'(v), 0);
        chk("R1 irq", int'(irq_kbd), 0);
        chk("R1 clk_oe", int'(ps2_clk_oe), 0);
        chk("R1 dat_oe", int'(ps2_dat_oe), 0);
    endtask

    task automatic t_translate;
        logic [7:0] v;
        kb_send(8'h1C, 1'b0, 1'b0);
        peek_status(v);
        chk("R6 obf bit", int'(v), 8'h01);
        expect_code("R3 1C", model_xlate(8'h1C));
        kb_send(8'h5A, 1'b0, 1'b0);
        expect_code("R3 5A", model_xlate(8'h5A));
        kb_send(8'h76, 1'b0, 1'b0);
        expect_code("R3 76", model_xlate(8'h76));
        kb_send(8'h4D, 1'b0, 1'b0);
        expect_code("R3 passthrough", 8'h4D);
    endtask

    task automatic t_break;
        kb_send(8'hF0, 1'b0, 1'b0);
        chk("R4 prefix not buffered", int'(irq_kbd), 0);
        kb_send(8'h5A, 1'b0, 1'b0);
        expect_code("R4 break code", 8'h9C);
        kb_send(8'h1C, 1'b0, 1'b0);
        expect_code("R4 marker cleared", 8'h1E);
    endtask

    task automatic t_errors;
        logic [7:0] v;
        kb_send(8'h1C, 1'b1, 1'b0);
        chk("R2 bad parity dropped", int'(irq_kbd), 0);
        cpu_read(1'b1, v);
        chk("R2 perr set", int'(v), 8'h04);
        cpu_read(1'b1, v);
        chk("R2 perr cleared by read", int'(v), 0);
        kb_send(8'h32, 1'b0, 1'b1);
        chk("R2 bad stop dropped", int'(irq_kbd), 0);
        cpu_read(1'b1, v);
        chk("R2 perr on bad stop", int'(v), 8'h04);
    endtask

    task automatic t_overwrite;
        kb_send(8'h24, 1'b0, 1'b0);
        kb_send(8'h29, 1'b0, 1'b0);
        expect_code("R5 overwrite", 8'h39);
    endtask

    task automatic t_unsolicited_ack;
        kb_send(8'hFA, 1'b0, 1'b0);
        expect_code("R10 FA buffered", 8'hFA);
    endtask

    task automatic t_transmit;
        logic [7:0] v;
        int seen;
        cpu_write(1'b0, 8'hED);
        host_cycle(8'hED);
        peek_status(v);
        chk("R9 pending after frame", int'(v), 8'h02);
        cpu_write(1'b0, 8'h55);
        seen = 0;
        for (int i = 0; i < INH + 20; i++) begin
            @(negedge clk);
            if (ps2_clk_oe) seen = 1;
        end
        chk("R9 busy write ignored", seen, 0);
        kb_send(8'hFA, 1'b0, 1'b0);
        peek_status(v);
        chk("R9 ack consumed", int'(v), 0);
        chk("R9 ack no irq", int'(irq_kbd), 0);
        cpu_write(1'b0, 8'hF4);
        host_cycle(8'hF4);
        kb_send(8'hFA, 1'b0, 1'b0);
        peek_status(v);
        chk("R9 second ack", int'(v), 0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_translate();
        t_break();
        t_errors();
        t_overwrite();
        t_unsolicited_ack();
        t_transmit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule